// File: doc/BRIEF.md
# Oscillator Warm-Up Timer

This block measures out a stabilization interval for an oscillator before the system may switch onto it or leave a low-power state. Software first picks which of two free-running clock enables (a fast one or a slow one) feeds the timer, picks a power-of-two prescale, and writes an 8-bit warm-up value. A start strobe then launches the run. The block counts prescaled ticks of the chosen enable until the programmed interval has elapsed. It then emits a single-cycle done pulse and drops its busy status.

Software reaches the block through a plain single-cycle register port with no back-pressure. A write completes in the cycle `bus_wr` is high. Read data is a combinational function of `bus_addr` and is valid in the same cycle. There is no streaming data path, so every pin is plain control or status. Address 0 holds the configuration register. Writing a 1 to its top bit aborts a run, and that bit always reads back as 0. Address 1 holds the warm-up value.

Top module: `osc_warmup_timer`

## Requirements
- R1: After reset, `busy` and `done` are 0, the configuration register reads 0x0D (prescale code 11, source 0), and the value register reads 0x00.
- R2: A read at address 0 returns bits 7..4 as 0, bits 3..2 as the prescale code, bit 1 as the source select and bit 0 as 1. A read at address 1 returns the 8-bit value last written there.
- R3: A `start` seen at a clock edge while idle makes `busy` high after that edge and begins the count from zero. A `start` while busy has no effect.
- R4: With source select 0, only `hs_tick` advances the timer. With source select 1, only `ls_tick` advances it.
- R5: Prescale codes 00, 01, 10 and 11 make one counted tick every 1, 2, 4 or 8 cycles in which the selected enable is high, respectively.
- R6: The run ends after 16*N counted ticks for a latched value N of 1..255, and after 16 ticks for N = 0. At the edge that takes the final tick, `busy` falls and `done` goes high for exactly one cycle.
- R7: A write at address 0 with bit 7 set clears and stops the timer. `busy` is low after that edge and no `done` follows. This clear wins over a simultaneous `start` or final tick.
- R8: Writes to the source or prescale bits while `busy` is high are ignored. A value-register write while busy is stored but affects only the next run, because N is latched at start.
- R9: `done` is never high while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register select: 0 configuration, 1 warm-up value |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| hs_tick | input | 1 | Fast-oscillator clock enable |
| ls_tick | input | 1 | Slow-oscillator clock enable |
| start | input | 1 | Start strobe |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Register writes and `start` take effect at the edge that samples them, so `busy` and read-back change one cycle later. Read data follows `bus_addr` within the same cycle. `done` appears after the edge carrying the final counted tick, which gives 16·N·prescale+1 edges from the start edge when the fast enable is high every cycle. The bench drives inputs on the falling edge and samples a quarter period after the rising edge. A behavioural model that advances on the same rising edge is compared every cycle against `busy`, `done` and `bus_rdata`. Directed checks also compare the measured start-to-done edge count with that formula.

// File: rtl/owu_pkg.sv
package owu_pkg;
  localparam int VAL_W    = 8;
  localparam int SHIFT    = 4;
  localparam int CNT_W    = VAL_W + SHIFT;
  localparam int PSEL_W   = 2;
  localparam int PCNT_W   = (1 << PSEL_W) - 1;
  localparam int CFG_BIT_CLR = 7;

  typedef struct packed {
    logic [PSEL_W-1:0] div_sel;
    logic              src_sel;
  } owu_cfg_t;

  localparam owu_cfg_t CFG_RESET = '{div_sel: 2'b11, src_sel: 1'b0};
endpackage

// File: rtl/owu_regs.sv
module owu_regs
  import owu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_addr,
  input  logic [VAL_W-1:0] bus_wdata,
  input  logic             busy,
  output owu_cfg_t         cfg,
  output logic [VAL_W-1:0] wu_val,
  output logic             clr_req,
  output logic [VAL_W-1:0] bus_rdata
);
  logic wr_cfg, wr_val;
  logic unused_wbits;

  assign wr_cfg  = bus_wr && !bus_addr;
  assign wr_val  = bus_wr &&  bus_addr;
  assign clr_req = wr_cfg && bus_wdata[CFG_BIT_CLR];
  assign unused_wbits = ^{bus_wdata[6:4], bus_wdata[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg    <= CFG_RESET;
      wu_val <= '0;
    end else begin
      if (wr_cfg && !busy) begin
        cfg.div_sel <= bus_wdata[3:2];
        cfg.src_sel <= bus_wdata[1];
      end
      if (wr_val) wu_val <= bus_wdata;
    end
  end

  always_comb begin
    if (bus_addr) bus_rdata = wu_val;
    else          bus_rdata = {4'b0000, cfg.div_sel, cfg.src_sel, 1'b1};
  end
endmodule

// File: rtl/owu_prescaler.sv
module owu_prescaler
  import owu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              restart,
  input  logic              hs_tick,
  input  logic              ls_tick,
  input  owu_cfg_t          cfg,
  output logic              pre_tick
);
  logic              src_tick;
  logic [PCNT_W-1:0] pre_cnt;
  logic [PCNT_W-1:0] mask;

  assign src_tick = cfg.src_sel ? ls_tick : hs_tick;
  assign mask     = PCNT_W'((1 << cfg.div_sel) - 1);
  assign pre_tick = run && src_tick && ((pre_cnt & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pre_cnt <= '0;
    else if (restart)          pre_cnt <= '0;
    else if (run && src_tick)  pre_cnt <= pre_cnt + 1'b1;
  end
endmodule

// File: rtl/owu_counter.sv
module owu_counter
  import owu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             start_acc,
  input  logic             pre_tick,
  input  logic [VAL_W-1:0] wu_val,
  output logic             busy,
  output logic             done
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] term;
  logic [CNT_W-1:0] term_d;

  assign term_d = (wu_val == '0) ? CNT_W'(1 << SHIFT) : (CNT_W'(wu_val) << SHIFT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
      term <= '0;
    end else begin
      done <= 1'b0;
      if (clr) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else if (start_acc) begin
        busy <= 1'b1;
        cnt  <= '0;
        term <= term_d;
      end else if (busy && pre_tick) begin
        if (cnt == term - 1'b1) begin
          busy <= 1'b0;
          done <= 1'b1;
          cnt  <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/osc_warmup_timer.sv
module osc_warmup_timer
  import owu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_addr,
  input  logic [VAL_W-1:0] bus_wdata,
  output logic [VAL_W-1:0] bus_rdata,
  input  logic             hs_tick,
  input  logic             ls_tick,
  input  logic             start,
  output logic             busy,
  output logic             done
);
  owu_cfg_t         cfg;
  logic [VAL_W-1:0] wu_val;
  logic             clr_req;
  logic             start_acc;
  logic             pre_tick;

  assign start_acc = start && !busy && !clr_req;

  owu_regs u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .busy(busy), .cfg(cfg), .wu_val(wu_val),
    .clr_req(clr_req), .bus_rdata(bus_rdata)
  );

  owu_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .run(busy), .restart(start_acc || clr_req),
    .hs_tick(hs_tick), .ls_tick(ls_tick), .cfg(cfg), .pre_tick(pre_tick)
  );

  owu_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(clr_req), .start_acc(start_acc),
    .pre_tick(pre_tick), .wu_val(wu_val), .busy(busy), .done(done)
  );
endmodule

// File: rtl/owu_checker.sv
module owu_checker
  import owu_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             bus_addr,
  input logic [VAL_W-1:0] bus_rdata,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             clr_req,
  input owu_cfg_t         cfg
);
  a_r1_idle_after_reset: assert property (@(posedge clk) $rose(rst_n) |-> !busy && !done);

  a_r2_cfg_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_addr |-> (bus_rdata[7:4] == 4'b0000) && bus_rdata[0]);

  a_r3_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !clr_req) |=> busy);

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r6_done_ends_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));

  a_r7_clear_stops: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |=> !busy && !done);

  a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cfg));

  a_r9_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind osc_warmup_timer owu_checker u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .start(start), .busy(busy), .done(done), .clr_req(clr_req), .cfg(cfg)
);

// File: tb/tb_osc_warmup_timer.sv
`timescale 1ns/1ps
module tb_osc_warmup_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_addr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       hs_tick = 1'b0;
  logic       ls_tick = 1'b0;
  logic       start = 1'b0;
  logic       busy, done;

  int  n_checks = 0;
  int  n_fail = 0;
  int  cyc = 0;
  bit  hs_rand = 1'b0;
  bit  finished = 1'b0;
  string cur_req = "R1";

  // behavioural reference state
  int m_busy = 0, m_done = 0, m_cnt = 0, m_s = 0, m_term = 0;
  int m_src = 0, m_div = 3, m_data = 0;

  always #10 clk = ~clk;

  osc_warmup_timer dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hs_tick(hs_tick),
    .ls_tick(ls_tick), .start(start), .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  // enable generators
  always @(negedge clk) begin
    cyc++;
    hs_tick <= hs_rand ? 1'($urandom % 2) : 1'b1;
    ls_tick <= (cyc % 3 == 0);
  end

  // reference model, advanced on the same edge as the design
  always @(posedge clk) begin
    int clr, st, pt, dv, n_busy, n_done, n_cnt, n_s;
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_cnt = 0; m_s = 0; m_term = 0;
      m_src = 0; m_div = 3; m_data = 0;
    end else begin
      clr = (bus_wr && !bus_addr && bus_wdata[7]) ? 1 : 0;
      st  = m_src ? int'(ls_tick) : int'(hs_tick);
      dv  = 1 << m_div;
      pt  = 0;
      n_s = m_s;
      if (m_busy && st) begin
        n_s = m_s + 1;
        if (n_s % dv == 0) pt = 1;
      end
      n_busy = m_busy; n_done = 0; n_cnt = m_cnt;
      if (clr) begin
        n_busy = 0; n_cnt = 0; n_s = 0;
      end else if (start && !m_busy) begin
        n_busy = 1; n_cnt = 0; n_s = 0;
        m_term = (m_data == 0) ? 16 : m_data * 16;
      end else if (m_busy && pt) begin
        n_cnt = m_cnt + 1;
        if (n_cnt == m_term) begin
          n_busy = 0; n_done = 1; n_cnt = 0;
        end
      end
      if (bus_wr && !bus_addr && !m_busy) begin
        m_src = int'(bus_wdata[1]);
        m_div = int'(bus_wdata[3:2]);
      end
      if (bus_wr && bus_addr) m_data = int'(bus_wdata);
      m_busy = n_busy; m_done = n_done; m_cnt = n_cnt; m_s = n_s;
    end
  end

  // per-cycle comparison, quarter period after the rising edge
  always begin
    int exp_rd;
    @(posedge clk);
    #5;
    if (rst_n) begin
      exp_rd = bus_addr ? m_data : ((m_div << 2) | (m_src << 1) | 1);
      check(busy == 1'(m_busy), cur_req, "busy", int'(busy), m_busy);
      check(done == 1'(m_done), cur_req, "done", int'(done), m_done);
      check(int'(bus_rdata) == exp_rd, cur_req, "rdata", int'(bus_rdata), exp_rd);
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "WATCHDOG", "timeout", 0, 1);
    finish_run();
  end

  task automatic wr(input bit a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = 8'h00;
  endtask

  task automatic rd_check(input bit a, input int exp, input string req);
    @(negedge clk);
    bus_addr = a;
    #1;
    check(int'(bus_rdata) == exp, req, "readback", int'(bus_rdata), exp);
  endtask

  // start and measure edges until done; returns edge count
  task automatic timed_run(output int n);
    @(negedge clk);
    start = 1'b1;
    n = 0;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    forever begin
      @(posedge clk);
      n++;
      #5;
      if (done) break;
    end
  endtask

  task automatic wait_idle();
    while (m_busy != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    cur_req = "R1";
    check(!busy && !done, "R1", "busy|done after reset", int'(busy | done), 0);
    rd_check(1'b0, 8'h0D, "R1");
    rd_check(1'b1, 8'h00, "R1");

    // R6 + R5: default prescale /8, N=0 -> 16 ticks
    cur_req = "R6";
    timed_run(n);
    check(n == 16 * 8 + 1, "R6", "edges to done N=0 div8", n, 129);
    wait_idle();

    // R5: prescale codes with N=1
    cur_req = "R5";
    wr(1'b1, 8'd1);
    for (int c = 0; c < 3; c++) begin
      wr(1'b0, 8'(c << 2));
      rd_check(1'b0, (c << 2) | 1, "R2");
      timed_run(n);
      check(n == 16 * (1 << c) + 1, "R5", "edges to done per prescale", n, 16 * (1 << c) + 1);
      wait_idle();
    end

    // R6: largest value, divide by 1
    cur_req = "R6";
    wr(1'b1, 8'd255);
    wr(1'b0, 8'h00);
    timed_run(n);
    check(n == 4080 + 1, "R6", "edges to done N=255", n, 4081);
    wait_idle();

    // R4: slow source, random fast enable
    cur_req = "R4";
    hs_rand = 1'b1;
    wr(1'b1, 8'd2);
    wr(1'b0, 8'h02);
    rd_check(1'b0, 8'h03, "R2");
    timed_run(n);
    check(n > 32 * 3 - 3 && n < 32 * 3 + 4, "R4", "edges to done on slow source", n, 96);
    wait_idle();
    // fast source with random enable
    wr(1'b0, 8'h04);
    wr(1'b1, 8'd1);
    timed_run(n);
    check(n > 32, "R4", "random fast enable stretches run", n, 33);
    wait_idle();
    hs_rand = 1'b0;

    // R3 + R8: start while busy, config and value writes while busy
    cur_req = "R8";
    wr(1'b0, 8'h00);
    wr(1'b1, 8'd2);
    @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (5) @(negedge clk);
    cur_req = "R3";
    start = 1'b1; @(negedge clk); start = 1'b0;
    check(busy == 1'b1, "R3", "busy held through second start", int'(busy), 1);
    cur_req = "R8";
    wr(1'b0, 8'h0E);
    rd_check(1'b0, 8'h01, "R8");
    wr(1'b1, 8'd5);
    rd_check(1'b1, 8'd5, "R8");
    wait_idle();
    // run should have used N=2: 32 edges from first start, already compared by model
    timed_run(n);
    check(n == 5 * 16 + 1, "R8", "value written while busy used on next run", n, 81);
    wait_idle();

    // R7: clear mid-run, clear with start, clear bit reads back 0
    cur_req = "R7";
    wr(1'b1, 8'd3);
    @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (10) @(negedge clk);
    wr(1'b0, 8'h80);
    check(busy == 1'b0, "R7", "busy after clear", int'(busy), 0);
    rd_check(1'b0, 8'h01, "R7");
    repeat (60) @(negedge clk);
    check(done == 1'b0 && m_done == 0, "R7", "no done after clear", int'(done), 0);
    @(negedge clk);
    start = 1'b1; bus_wr = 1'b1; bus_addr = 1'b0; bus_wdata = 8'h84;
    @(negedge clk);
    start = 1'b0; bus_wr = 1'b0; bus_wdata = 8'h00;
    check(busy == 1'b0, "R7", "clear beats start", int'(busy), 0);
    rd_check(1'b0, 8'h05, "R7");

    // R9: exercised throughout by the per-cycle done/busy comparison
    cur_req = "R9";
    wr(1'b0, 8'h00);
    wr(1'b1, 8'd0);
    timed_run(n);
    check(!busy, "R9", "busy low with done", int'(busy), 0);
    wait_idle();

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule